// File: doc/BRIEF.md
# Speculative One-Tap Decision Feedback Slicer

This block turns a stream of signed, quantized receiver samples (one per unit interval) into recovered bits. It cancels the first post-cursor inter-symbol interference, which is the part of the previous symbol that leaks into the current sample. A user-supplied first-tap weight `h1` sets the size of that correction. The block does not subtract a weighted copy of the last decision before slicing. Instead, two comparators slice every sample at the same time. The upper one uses threshold `+h1`, which assumes the previous bit was 1 and pushed the sample up. The lower one uses `-h1`, which assumes the previous bit was 0 (symbol -1) and pushed it down. The resolved previous bit then drives a two-way select, much as a carry-select adder does. The only logic inside the feedback loop is one multiplexer, and the arithmetic sits outside it.

A small state machine tracks whether any bit has been resolved since reset. It has two states:
- `ST_SEED`: the state after reset. The lower comparator is used, so the decision is made as if the previous bit were 0.
- `ST_TRACK`: the state after the first valid sample. The registered previous decision drives the select.

There are two transitions:
- `ST_SEED` to `ST_TRACK`: taken on the first cycle with `in_vld` high.
- `ST_TRACK` to `ST_TRACK`: the state holds until reset.

The decision register is also the previous-bit register. It is updated only by valid samples. Each result appears one clock after its sample, together with a valid strobe.

Top module: `udfe_top`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by exactly one clock. During and after reset, `out_vld` and `out_bit` are 0 until the first valid sample has been registered.
- R2: On every sample, the upper decision is `sample >= +h1` and the lower decision is `sample >= -h1`. Both compare as signed values. The upper decision being 1 implies that the lower decision is 1.
- R3: When the previous resolved bit is 1, the output is the upper decision. When it is 0, the output is the lower decision.
- R4: For the first valid sample after reset, the decision is made against `-h1`. For example, sample -10 with `h1` = 20 gives 1.
- R5: A cycle with `in_vld` low leaves `out_bit` and the stored previous bit unchanged, whatever `sample` and `h1` carry on that cycle.
- R6: Comparisons are done in widened signed arithmetic, and each threshold saturates to the sample range. The comparison never wraps:
  - sample 127 with `h1` = 127 and previous bit 1 gives 1.
  - sample -128 with `h1` = 127 and previous bit 0 gives 0.
- R7: Every decision equals direct subtraction: `(sample - (prev ? h1 : -h1)) >= 0`.
- R8: `h1` is taken on the same clock edge as the sample it applies to, while `in_vld` is high. A new `h1` affects the decision for that same sample.
- R9: Each received sample is `(b ? A : -A) + (p ? h1 : -h1)`, where `b` is the current transmitted bit, `p` is the previous transmitted bit, and `A` is the amplitude. With `A > h1`, the recovered bits equal the transmitted bits. This includes the pattern 1-0-1-1-0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample valid strobe |
| sample | input | SW (8) | Signed two's-complement input sample |
| h1 | input | HW (7) | Unsigned first post-cursor tap weight |
| out_bit | output | 1 | Recovered bit, also the previous-bit state |
| out_vld | output | 1 | High one clock after a valid sample |

## Verification
The assertions take for granted that `in_vld` is held low during reset, so the past values used after reset are defined. They also assume `sample` and `h1` are known whenever `in_vld` is high. The bench meets both conditions:
- It keeps `in_vld` low throughout reset.
- It drives inputs only on falling edges.
- It draws every sample from a bounded channel model or from the full 8-bit range, and every `h1` from the 7-bit range.
- It changes `h1` only at frame boundaries in the channel runs, and checks R8 explicitly on single samples.

// File: rtl/udfe_pkg.sv
package udfe_pkg;

    typedef enum logic [0:0] {
        ST_SEED  = 1'b0,
        ST_TRACK = 1'b1
    } udfe_state_e;

endpackage

// File: rtl/udfe_slicer.sv
module udfe_slicer #(
    parameter int SW    = 8,
    parameter int HW    = 7,
    parameter bit UPPER = 1'b1
) (
    input  logic signed [SW-1:0] sample,
    input  logic        [HW-1:0] h1,
    output logic                 decide
);

    localparam int EW     = ((SW > HW + 1) ? SW : HW + 1) + 1;
    localparam int TMAX_I = (1 << (SW - 1)) - 1;
    localparam int TMIN_I = -(1 << (SW - 1));
    localparam logic signed [EW-1:0] TMAX = EW'(TMAX_I);
    localparam logic signed [EW-1:0] TMIN = EW'(TMIN_I);

    logic signed [EW-1:0] s_ext;
    logic signed [EW-1:0] mag;
    logic signed [EW-1:0] thr_raw;
    logic signed [EW-1:0] thr;

    assign s_ext = {{(EW - SW){sample[SW-1]}}, sample};
    assign mag   = {{(EW - HW){1'b0}}, h1};

    generate
        if (UPPER) begin : g_up
            assign thr_raw = mag;
        end else begin : g_dn
            assign thr_raw = -mag;
        end
    endgenerate

    always_comb begin
        if (thr_raw > TMAX) begin
            thr = TMAX;
        end else if (thr_raw < TMIN) begin
            thr = TMIN;
        end else begin
            thr = thr_raw;
        end
    end

    assign decide = (s_ext >= thr);

endmodule

// File: rtl/udfe_decide.sv
module udfe_decide
    import udfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic dec_hi,
    input  logic dec_lo,
    output logic out_bit,
    output logic out_vld
);

    udfe_state_e state_q;
    udfe_state_e state_d;
    logic        pick;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEED:  state_d = in_vld ? ST_TRACK : ST_SEED;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_SEED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pick = dec_lo;
        unique case (state_q)
            ST_SEED:  pick = dec_lo;
            ST_TRACK: pick = out_bit ? dec_hi : dec_lo;
            default:  pick = dec_lo;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_bit <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_bit <= pick;
            end
        end
    end

endmodule

// File: rtl/udfe_top.sv
module udfe_top #(
    parameter int SW = 8,
    parameter int HW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [SW-1:0] sample,
    input  logic        [HW-1:0] h1,
    output logic                 out_bit,
    output logic                 out_vld
);

    logic w_hi;
    logic w_lo;

    udfe_slicer #(.SW(SW), .HW(HW), .UPPER(1'b1)) u_hi (
        .sample (sample),
        .h1     (h1),
        .decide (w_hi)
    );

    udfe_slicer #(.SW(SW), .HW(HW), .UPPER(1'b0)) u_lo (
        .sample (sample),
        .h1     (h1),
        .decide (w_lo)
    );

    udfe_decide u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .dec_hi  (w_hi),
        .dec_lo  (w_lo),
        .out_bit (out_bit),
        .out_vld (out_vld)
    );

endmodule

// File: rtl/udfe_chk.sv
module udfe_chk #(
    parameter int SW = 8,
    parameter int HW = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_vld,
    input logic signed [SW-1:0] sample,
    input logic        [HW-1:0] h1,
    input logic                 out_bit,
    input logic                 out_vld,
    input logic                 dec_hi,
    input logic                 dec_lo
);

    localparam int EW = ((SW > HW + 1) ? SW : HW + 1) + 2;

    logic signed [EW-1:0] s_w;
    logic signed [EW-1:0] h_w;
    logic signed [EW-1:0] diff;
    logic                 ref_now;

    // Reference decision by direct subtraction of the weighted previous bit.
    assign s_w     = {{(EW - SW){sample[SW-1]}}, sample};
    assign h_w     = {{(EW - HW){1'b0}}, h1};
    assign diff    = out_bit ? (s_w - h_w) : (s_w + h_w);
    assign ref_now = !diff[EW-1];

    a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    a_r1_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    a_r2_thr_order: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && dec_hi) |-> dec_lo);

    a_r5_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_bit));

    a_r7_subtract_eq: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_bit == $past(ref_now)));

endmodule

bind udfe_top udfe_chk #(.SW(SW), .HW(HW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .sample  (sample),
    .h1      (h1),
    .out_bit (out_bit),
    .out_vld (out_vld),
    .dec_hi  (w_hi),
    .dec_lo  (w_lo)
);

// File: tb/udfe_top_bench.sv
`timescale 1ns/1ps
module udfe_top_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic signed [7:0] sample = '0;
    logic        [6:0] h1 = '0;
    logic              out_bit;
    logic              out_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit m_prev = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    udfe_top u_udfe_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .sample  (sample),
        .h1      (h1),
        .out_bit (out_bit),
        .out_vld (out_vld)
    );

    function automatic bit exp_bit(int x, int h, bit prev);
        int thr;
        thr = prev ? h : -h;
        return (x >= thr);
    endfunction

    function automatic int chan(bit b, bit pb, int a, int h);
        return (b ? a : -a) + (pb ? h : -h);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive on a falling edge, check at the next falling edge.
    // txb >= 0 also compares against the transmitted bit.
    task automatic apply(bit v, int x, int h, string tag, int txb);
        bit e;
        @(negedge clk);
        in_vld = v;
        sample = 8'(x);
        h1     = 7'(h);
        e      = v ? exp_bit(x, h, m_prev) : m_prev;
        @(negedge clk);
        check({tag, " vld"}, int'(out_vld), int'(v));
        check({tag, " bit"}, int'(out_bit), int'(e));
        if (v && txb >= 0) begin
            check({"R9 tx ", tag}, int'(out_bit), txb);
        end
        m_prev = e;
        in_vld = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset vld", int'(out_vld), 0);
        check("R1 reset bit", int'(out_bit), 0);
        rst_n  = 1'b1;
        m_prev = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int a;
        int h;
        bit pb;
        bit b;
        bit pat[5];

        // R1 / R4: reset state, then the first decision uses -h1.
        do_reset();
        apply(1'b1, -10, 20, "R4 first uses -h1", 1);

        // R3: the previous 1 selects the upper comparator.
        apply(1'b1, 10, 20, "R3 prev1 upper", 0);
        apply(1'b1, -10, 20, "R3 prev0 lower", 1);
        apply(1'b1, 25, 20, "R3 prev1 above", 1);

        // R5: an invalid cycle with a flipping sample leaves state as is.
        apply(1'b0, -128, 0, "R5 ignored", -1);
        apply(1'b1, 15, 20, "R5 prev kept", 0);

        // R8: h1 is taken with the same sample.
        apply(1'b1, -30, 20, "R8 h pre", 0);
        apply(1'b1, -30, 40, "R8 h new", 1);

        // R6: range extremes.
        apply(1'b1, 127, 127, "R6 max vs +127", 1);
        apply(1'b1, -128, 127, "R6 min vs +127", 0);
        apply(1'b1, -128, 127, "R6 min vs -127", 0);
        apply(1'b1, -127, 127, "R6 -127 vs -127", 1);
        apply(1'b1, 127, 0, "R2 h zero", 1);
        apply(1'b1, -1, 0, "R2 h zero neg", 0);

        // R9: pattern 1-0-1-1-0 through a one-tap channel.
        do_reset();
        pat = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        pb  = 1'b0;
        for (int i = 0; i < 5; i++) begin
            apply(1'b1, chan(pat[i], pb, 60, 30), 30, "R9 pattern", int'(pat[i]));
            pb = pat[i];
        end

        // R7 / R2: raw random samples against the subtraction model.
        void'($urandom(32'h5eed_0d1f));
        for (int i = 0; i < 1500; i++) begin
            apply(($urandom % 8) != 0, int'($urandom % 256) - 128,
                  int'($urandom % 128), "R7 random", -1);
        end

        // R9: random framed channel traffic.
        do_reset();
        pb = 1'b0;
        a  = 60;
        h  = 20;
        for (int i = 0; i < 3000; i++) begin
            if (i % 100 == 0) begin
                h = int'($urandom % 51);
                a = h + 1 + int'($urandom % (127 - 2 * h));
            end
            if (($urandom % 8) == 0) begin
                apply(1'b0, int'($urandom % 256) - 128, h, "R5 gap", -1);
            end else begin
                b = 1'($urandom);
                apply(1'b1, chan(b, pb, a, h), h, "R9 channel", int'(b));
                pb = b;
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule